// File: doc/BRIEF.md
# Presettable 4-bit Up/Down Counter

This block is a small binary counter that steps one count up or one count down on each rising clock edge while its active-low count enable is held low. The up/down input picks the direction. A level-sensitive parallel load copies a data word into the count at any moment, with or without a clock edge. An asynchronous master reset clears the count and overrides every other input, the load included.

An active-low terminal-count output flags the end of the range in the current direction: all ones when counting up, all zeros when counting down. It goes low only while counting is enabled. It is purely combinational, so it reacts at once to the enable, the direction and the count. The width is a parameter with a default of 4 bits. The count wraps modulo 2^WIDTH in both directions.

Top module: `updn_counter4`

## Requirements
- R1: While `mrst_i` is 1, `count_o` is 0000 at once, whatever the clock, load, data, direction or enable do.
- R2: While `pload_i` is 1 and `mrst_i` is 0, `count_o` equals `pdata_i` with no clock edge needed, and it follows every change of `pdata_i`. The clock, the enable and the direction have no effect.
- R3: With `mrst_i`=0, `pload_i`=0, `cen_n_i`=0 and `up_i`=1, each rising edge of `clk_i` adds one to `count_o`.
- R4: With `mrst_i`=0, `pload_i`=0, `cen_n_i`=0 and `up_i`=0, each rising edge of `clk_i` subtracts one from `count_o`.
- R5: With `cen_n_i`=1 and `mrst_i`=`pload_i`=0, `count_o` keeps its value across clock edges in either direction.
- R6: With `up_i`=1, `cen_n_i`=0 and `count_o`=1111, `term_n_o` is 0.
- R7: With `up_i`=0, `cen_n_i`=0 and `count_o`=0000, `term_n_o` is 0.
- R8: In every other case `term_n_o` is 1. This includes any cycle with `cen_n_i`=1, whatever the count.
- R9: The count wraps. Counting up from 1111 gives 0000, and counting down from 0000 gives 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock, rising edge |
| mrst_i | input | 1 | Asynchronous master reset, active high |
| pload_i | input | 1 | Level-sensitive parallel load, active high |
| pdata_i | input | WIDTH | Parallel data to load |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| cen_n_i | input | 1 | Count enable, active low |
| count_o | output | WIDTH | Current count |
| term_n_o | output | 1 | Terminal count, active low |

## Verification
Two pairs of functions can act in the same cycle. Reset can meet load, and load can meet a clock edge that would otherwise count. The bench raises reset between edges while load is driving a non-zero word and expects 0000 at once. It then drops reset while load is still high and expects the data to appear without waiting for an edge. It also holds load high across a rising edge with the count enabled and expects the loaded value, not a step from it. Terminal count is judged both after edges and between them, by toggling the enable mid-cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Action the clock edge performs when no override is active.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_mode_e;

  // Enable is active low; direction 1 means increment.
  function automatic cnt_mode_e select_mode(input logic cen_n, input logic up);
    if (cen_n)   return CNT_HOLD;
    else if (up) return CNT_UP;
    else         return CNT_DOWN;
  endfunction

endpackage

// File: rtl/updn_step.sv
module updn_step
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  cnt_mode_e        mode_i,
  output logic [WIDTH-1:0] nxt_o
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // Modulo 2^WIDTH step; natural wrap of the fixed-width sum.
  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] v,
                                               input cnt_mode_e m);
    case (m)
      CNT_UP:   return v + ONE;
      CNT_DOWN: return v - ONE;
      default:  return v;
    endcase
  endfunction

  always_comb nxt_o = advance(cur_i, mode_i);

endmodule

// File: rtl/updn_bitreg.sv
module updn_bitreg (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);

  // One count bit with asynchronous clear (highest priority) and set.
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end

endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_i,
  input  logic             cen_n_i,
  output logic             term_n_o
);

  logic hit_top;
  logic hit_bottom;
  logic end_reached;

  assign hit_top     = &count_i;
  assign hit_bottom  = ~|count_i;
  assign end_reached = up_i ? hit_top : hit_bottom;
  assign term_n_o    = ~(end_reached & ~cen_n_i);

endmodule

// File: rtl/updn_counter4.sv
module updn_counter4
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             pload_i,
  input  logic [WIDTH-1:0] pdata_i,
  input  logic             up_i,
  input  logic             cen_n_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_n_o
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  cnt_mode_e        mode;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] set_vec;
  logic [WIDTH-1:0] clr_vec;
  logic             load_live;

  assign mode      = select_mode(cen_n_i, up_i);
  assign load_live = pload_i & ~mrst_i;

  updn_step #(.WIDTH(WIDTH)) u_step (
    .cur_i  (count_o),
    .mode_i (mode),
    .nxt_o  (nxt)
  );

  // Load becomes a per-bit async preset/clear; reset masks the preset.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign set_vec[b] = load_live & pdata_i[b];
    assign clr_vec[b] = mrst_i | (pload_i & ~pdata_i[b]);

    updn_bitreg u_bit (
      .clk_i (clk_i),
      .set_i (set_vec[b]),
      .clr_i (clr_vec[b]),
      .d_i   (nxt[b]),
      .q_o   (count_o[b])
    );
  end

  updn_term #(.WIDTH(WIDTH)) u_term (
    .count_i  (count_o),
    .up_i     (up_i),
    .cen_n_i  (cen_n_i),
    .term_n_o (term_n_o)
  );

  // Level overrides, sampled mid-cycle.
  always @(negedge clk_i) begin
    if (mrst_i)
      assert_reset_clears_R1: assert (count_o == ZERO);
    if (pload_i && !mrst_i)
      assert_load_follows_R2: assert (count_o == pdata_i);
  end

  // Clocked stepping.
  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!pload_i && !cen_n_i && up_i) |=> (pload_i || count_o == $past(count_o) + ONE));

  assert_step_down_R4: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!pload_i && !cen_n_i && !up_i) |=> (pload_i || count_o == $past(count_o) - ONE));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!pload_i && cen_n_i) |=> (pload_i || $stable(count_o)));

  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!pload_i && !cen_n_i && up_i && count_o == ONES) |=> (pload_i || count_o == ZERO));

  // Terminal count.
  assert_term_up_R6: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!cen_n_i && up_i && count_o == ONES) |-> !term_n_o);

  assert_term_down_R7: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!cen_n_i && !up_i && count_o == ZERO) |-> !term_n_o);

  assert_term_idle_R8: assert property (@(posedge clk_i) disable iff (mrst_i)
    cen_n_i |-> term_n_o);

endmodule

// File: tb/updn_counter4_test.sv
`timescale 1ns/100ps
module updn_counter4_test;

  localparam int W = 4;
  localparam int NV = 24;

  logic         clk = 1'b0;
  logic         mrst = 1'b1;
  logic         pload = 1'b0;
  logic [W-1:0] pdata = '0;
  logic         up = 1'b1;
  logic         cen_n = 1'b1;
  logic [W-1:0] count;
  logic         term_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  updn_counter4 #(.WIDTH(W)) uut (
    .clk_i    (clk),
    .mrst_i   (mrst),
    .pload_i  (pload),
    .pdata_i  (pdata),
    .up_i     (up),
    .cen_n_i  (cen_n),
    .count_o  (count),
    .term_n_o (term_n)
  );

  // {rst, load, data[3:0], up, cen_n, exp_count[3:0], exp_term_n}
  localparam logic [12:0] VEC [NV] = '{
    13'b1_0_0000_0_1_0000_1,  //  1 R1 reset, R8 idle
    13'b0_1_1010_1_0_1010_1,  //  2 R2 load held across edge
    13'b0_0_0000_1_0_1011_1,  //  3 R3 up
    13'b0_0_0000_1_0_1100_1,  //  4 R3 up
    13'b0_0_0000_1_1_1100_1,  //  5 R5 hold
    13'b0_0_0000_0_0_1011_1,  //  6 R4 down
    13'b0_1_1111_1_1_1111_1,  //  7 R8 all ones but disabled
    13'b0_1_1111_1_0_1111_0,  //  8 R6 term up
    13'b0_0_0000_1_0_0000_1,  //  9 R9 wrap up
    13'b0_0_0000_0_0_1111_1,  // 10 R9 wrap down
    13'b0_1_0001_0_1_0001_1,  // 11 R2 load
    13'b0_0_0000_0_0_0000_0,  // 12 R7 term down
    13'b0_0_0000_0_0_1111_1,  // 13 R9 wrap down
    13'b0_0_0000_1_0_0000_1,  // 14 R9 wrap up
    13'b1_1_0110_1_0_0000_1,  // 15 R1 reset beats load
    13'b0_1_0110_1_0_0110_1,  // 16 R2 load after reset release
    13'b0_0_0000_1_0_0111_1,  // 17 R3 up
    13'b0_0_0000_1_1_0111_1,  // 18 R5 hold up
    13'b0_0_0000_0_1_0111_1,  // 19 R5 hold down
    13'b0_0_0000_0_0_0110_1,  // 20 R4 down
    13'b0_1_1110_0_0_1110_1,  // 21 R2 load
    13'b0_0_0000_1_0_1111_0,  // 22 R3 up into R6 term
    13'b0_0_0000_1_1_1111_1,  // 23 R5 hold, R8 idle
    13'b0_0_0000_0_0_1110_1   // 24 R4 down
  };

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", count, 0);
    check("R8 reset term", term_n, 1);
    mrst = 1'b0;

    // Vector walk: drive after an edge, judge after the next edge.
    for (int i = 0; i < NV; i++) begin
      mrst  = VEC[i][12];
      pload = VEC[i][11];
      pdata = VEC[i][10:7];
      up    = VEC[i][6];
      cen_n = VEC[i][5];
      @(posedge clk);
      #1;
      check($sformatf("vec%0d count", i + 1), count, VEC[i][4:1]);
      check($sformatf("vec%0d term", i + 1), term_n, VEC[i][0]);
    end

    // R2: load takes effect between edges and tracks data changes.
    mrst = 1'b0; pload = 1'b1; pdata = 4'b0101; up = 1'b1; cen_n = 1'b0;
    #0.3;
    check("R2 async load", count, 4'b0101);
    pdata = 4'b1001;
    #0.3;
    check("R2 load follows data", count, 4'b1001);
    @(posedge clk); #1;
    check("R2 load beats edge", count, 4'b1001);

    // R7/R8: term reacts to enable without an edge.
    pdata = 4'b0000; up = 1'b0; cen_n = 1'b1;
    #0.3;
    check("R8 term idle at zero", term_n, 1);
    cen_n = 1'b0;
    #0.3;
    check("R7 term on enable", term_n, 0);
    up = 1'b1;
    #0.2;
    check("R8 term wrong direction", term_n, 1);
    @(posedge clk); #1;

    // R1: reset mid-cycle overrides an active load of non-zero data.
    pdata = 4'b1100;
    #0.3;
    check("R2 load 1100", count, 4'b1100);
    mrst = 1'b1;
    #0.3;
    check("R1 async reset over load", count, 0);
    @(posedge clk); #1;
    check("R1 reset across edge", count, 0);
    mrst = 1'b0;
    #0.3;
    check("R2 load after reset drops", count, 4'b1100);
    @(posedge clk); #1;
    pload = 1'b0;
    @(posedge clk); #1;
    check("R3 up after load", count, 4'b1101);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule